// File: doc/BRIEF.md
# Two-Level Interrupt Request Controller

The controller gathers single-cycle raise pulses from up to 32 peripheral sources into a pending-flag register. It combines that register with a per-source enable mask and a single master enable to produce an interrupt request for the CPU. Software reaches the enable mask and the pending flags as two 16-bit halves each. A pending flag is cleared by writing a 1 to its position. A separate halt tracker records whether the CPU is halted. It ends the halt as soon as a source whose enable bit is set raises a pulse. The master enable plays no part in that wake decision.

Software writes the enable halves, the master enable, and write-1-to-clear patterns through one write port. It reads any register through a combinational read port. The request is recomputed from the values the registers take at the next edge, so a write to the mask or to the master enable takes effect straight away. The CPU's interrupt-disable flag gates delivery of the request. While the flag is set the request is held, and it is delivered when the flag clears.

Two small state machines carry the sequencing. The request machine has states `RQ_IDLE` and `RQ_ACTIVE`. Its transition *raise* goes from idle to active when the next-state master enable is 1 and the next-state enable AND pending is nonzero. Its transition *drop* goes back when either condition fails. The halt machine has states `HS_RUN` and `HS_HALT`. Its transition *enter* goes from run to halt on a `halt_req` pulse. Its transition *wake* goes from halt to run on a source pulse whose enable bit is set, and emits a one-cycle `wake` pulse.

Top module: `irqc_top`

## Requirements
- R1: After reset every register reads 0, `irq_req`, `irq_out` and `wake` are 0, and `halted` is 0.
- R2: Register addresses are 0 for the master enable (bit 0 only; other bits read 0), 1 for enable bits 15..0, 2 for enable bits 31..16, 3 for pending bits 15..0 and 4 for pending bits 31..16. Enable and master writes read back the written value from the next cycle on.
- R3: A pulse on `src_i[n]` sets pending bit n, which is readable in the cycle after the pulse. Bits 0..15 appear at address 3 and bits 16..31 at address 4, as bit n-16.
- R4: Writing to a pending half clears each bit written as 1 and leaves each bit written as 0 unchanged. The other half is not affected.
- R5: A source pulse and a write-1-to-clear of the same pending bit in the same cycle leave that bit set.
- R6: `irq_req` is 1 in the cycle after any cycle whose resulting register state has master enable 1 and enable AND pending nonzero. This includes the cycle after a write to the enable mask or the master enable.
- R7: `irq_req` returns to 0 in the cycle after the master enable is cleared or the last enabled pending bit is cleared or disabled.
- R8: `irq_out` equals `irq_req` while `cpu_irq_dis` is 0 and is 0 while it is 1. A held request appears on `irq_out` in the same cycle the flag clears.
- R9: A `halt_req` pulse while running makes `halted` 1 in the next cycle.
- R10: While halted, a source pulse whose enable bit is set makes `halted` 0 and `wake` 1 in the next cycle, even with the master enable at 0. `wake` lasts one cycle.
- R11: While halted, a source pulse whose enable bit is clear leaves `halted` at 1 and still sets its pending bit.
- R12: Writes to addresses 5..7 change no register, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Per-source raise pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Combinational read data |
| cpu_irq_dis | input | 1 | CPU interrupt-disable flag |
| halt_req | input | 1 | CPU asks to halt |
| irq_req | output | 1 | Registered interrupt request |
| irq_out | output | 1 | Request as delivered to the CPU |
| halted | output | 1 | CPU halted state |
| wake | output | 1 | One-cycle wake pulse |

## Verification
Every registered result is due exactly one cycle after the stimulus: pending and enable contents, `irq_req`, `halted` and `wake`. The read data and `irq_out` follow their inputs within the same cycle. The bench drives inputs 2 ns after a rising edge and updates its reference model on that rising edge. It compares all outputs on the falling edge, by which time the registered results have settled. Directed checks read registers back right after the edge that commits a write or pulse, so each check falls on the cycle the requirement names.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int RA_MASTER = 0;
    localparam int RA_EN_BASE = 1;

    typedef enum logic [0:0] {
        RQ_IDLE   = 1'b0,
        RQ_ACTIVE = 1'b1
    } req_state_e;

    typedef enum logic [0:0] {
        HS_RUN  = 1'b0,
        HS_HALT = 1'b1
    } halt_state_e;

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int HALF_W  = 16,
    parameter int ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [HALF_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [HALF_W-1:0]  rd_data,
    output logic               ime_q,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] pend_q,
    output logic               ime_nxt,
    output logic [NUM_SRC-1:0] en_nxt,
    output logic [NUM_SRC-1:0] pend_nxt
);

    localparam int NUM_HALVES = NUM_SRC / HALF_W;
    localparam int PEND_BASE  = RA_EN_BASE + NUM_HALVES;
    localparam int LAST_ADDR  = PEND_BASE + NUM_HALVES - 1;

    logic [NUM_SRC-1:0] clr_mask;

    assign ime_nxt = (wr_en && wr_addr == ADDR_W'(RA_MASTER)) ? wr_data[0] : ime_q;

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        logic en_we;
        logic pend_we;
        assign en_we   = wr_en && (wr_addr == ADDR_W'(RA_EN_BASE + h));
        assign pend_we = wr_en && (wr_addr == ADDR_W'(PEND_BASE + h));
        assign en_nxt[h*HALF_W +: HALF_W]   = en_we ? wr_data : en_q[h*HALF_W +: HALF_W];
        assign clr_mask[h*HALF_W +: HALF_W] = pend_we ? wr_data : '0;
    end

    // a raise pulse outranks a clear of the same bit
    assign pend_nxt = (pend_q & ~clr_mask) | src_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ime_q  <= 1'b0;
            en_q   <= '0;
            pend_q <= '0;
        end else begin
            ime_q  <= ime_nxt;
            en_q   <= en_nxt;
            pend_q <= pend_nxt;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(RA_MASTER)) begin
            rd_data[0] = ime_q;
        end
        for (int h = 0; h < NUM_HALVES; h++) begin
            if (rd_addr == ADDR_W'(RA_EN_BASE + h)) begin
                rd_data = en_q[h*HALF_W +: HALF_W];
            end
            if (rd_addr == ADDR_W'(PEND_BASE + h)) begin
                rd_data = pend_q[h*HALF_W +: HALF_W];
            end
        end
    end

    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_i) |=> ((pend_q & $past(src_i)) == $past(src_i))); // R3

    AST_PEND_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend_q) & ~pend_q) & ~$past(clr_mask)) == '0)); // R4

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src_i & clr_mask)) |=> ((pend_q & $past(src_i & clr_mask)) == $past(src_i & clr_mask))); // R5

    AST_BAD_ADDR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > ADDR_W'(LAST_ADDR)) |=> ($stable(en_q) && $stable(ime_q))); // R12

endmodule

// File: rtl/irqc_req_fsm.sv
module irqc_req_fsm
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ime_nxt,
    input  logic [NUM_SRC-1:0] en_nxt,
    input  logic [NUM_SRC-1:0] pend_nxt,
    input  logic               ime_q,
    input  logic [NUM_SRC-1:0] en_q,
    input  logic [NUM_SRC-1:0] pend_q,
    input  logic               cpu_irq_dis,
    output logic               irq_req,
    output logic               irq_out
);

    req_state_e state_q;
    req_state_e state_d;
    logic       want;

    assign want = ime_nxt && (|(en_nxt & pend_nxt));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RQ_IDLE:   if (want)  state_d = RQ_ACTIVE;  // raise
            RQ_ACTIVE: if (!want) state_d = RQ_IDLE;    // drop
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_req = (state_q == RQ_ACTIVE);
        irq_out = irq_req && !cpu_irq_dis;
    end

    AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (ime_q && (|(en_q & pend_q)))); // R6

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ime_q || ((en_q & pend_q) == '0)) |-> !irq_req); // R7

    AST_HOLD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq_dis |-> !irq_out); // R8

endmodule

// File: rtl/irqc_halt_fsm.sv
module irqc_halt_fsm
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               halt_req,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] en_q,
    output logic               halted,
    output logic               wake
);

    halt_state_e state_q;
    halt_state_e state_d;
    logic        wake_cond;
    logic        wake_q;

    // wake depends on the per-source enable only
    assign wake_cond = |(src_i & en_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_RUN:  if (halt_req)  state_d = HS_HALT;  // enter
            HS_HALT: if (wake_cond) state_d = HS_RUN;   // wake
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_RUN;
            wake_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            wake_q  <= (state_q == HS_HALT) && wake_cond;
        end
    end

    always_comb begin
        halted = (state_q == HS_HALT);
        wake   = wake_q;
    end

    AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(halt_req)); // R9

    AST_WAKE_FROM_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> ($past(halted) && !halted)); // R10

    AST_QUIET_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && ((src_i & en_q) == '0)) |=> halted); // R11

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int HALF_W  = 16,
    parameter int ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [HALF_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [HALF_W-1:0]  rd_data,
    input  logic               cpu_irq_dis,
    input  logic               halt_req,
    output logic               irq_req,
    output logic               irq_out,
    output logic               halted,
    output logic               wake
);

    logic               ime_q;
    logic               ime_nxt;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] en_nxt;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] pend_nxt;

    irqc_regs #(
        .NUM_SRC(NUM_SRC),
        .HALF_W (HALF_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src_i),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .ime_q   (ime_q),
        .en_q    (en_q),
        .pend_q  (pend_q),
        .ime_nxt (ime_nxt),
        .en_nxt  (en_nxt),
        .pend_nxt(pend_nxt)
    );

    irqc_req_fsm #(
        .NUM_SRC(NUM_SRC)
    ) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .ime_nxt    (ime_nxt),
        .en_nxt     (en_nxt),
        .pend_nxt   (pend_nxt),
        .ime_q      (ime_q),
        .en_q       (en_q),
        .pend_q     (pend_q),
        .cpu_irq_dis(cpu_irq_dis),
        .irq_req    (irq_req),
        .irq_out    (irq_out)
    );

    irqc_halt_fsm #(
        .NUM_SRC(NUM_SRC)
    ) u_halt (
        .clk     (clk),
        .rst_n   (rst_n),
        .halt_req(halt_req),
        .src_i   (src_i),
        .en_q    (en_q),
        .halted  (halted),
        .wake    (wake)
    );

endmodule

// File: tb/irqc_top_bench.sv
`timescale 1ns/1ps
module irqc_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        cpu_irq_dis = 1'b0;
    logic        halt_req = 1'b0;
    logic        irq_req, irq_out, halted, wake;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model state
    bit        m_ime;
    bit [31:0] m_en, m_pend;
    bit        m_irq, m_halted, m_wake;

    always #4 clk = ~clk;

    irqc_top u_irqc_top (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .cpu_irq_dis(cpu_irq_dis), .halt_req(halt_req),
        .irq_req(irq_req), .irq_out(irq_out), .halted(halted), .wake(wake)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ime = 0; m_en = 0; m_pend = 0; m_irq = 0; m_halted = 0; m_wake = 0;
        end else begin
            bit        n_ime;
            bit [31:0] n_en, clr;
            n_ime = m_ime; n_en = m_en; clr = 0;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: n_ime = wr_data[0];
                    3'd1: n_en[15:0] = wr_data;
                    3'd2: n_en[31:16] = wr_data;
                    3'd3: clr[15:0] = wr_data;
                    3'd4: clr[31:16] = wr_data;
                    default: ;
                endcase
            end
            m_wake = m_halted && ((src_i & m_en) != 0);
            if (!m_halted) m_halted = halt_req;
            else if ((src_i & m_en) != 0) m_halted = 0;
            m_pend = (m_pend & ~clr) | src_i;
            m_en = n_en;
            m_ime = n_ime;
            m_irq = m_ime && ((m_en & m_pend) != 0);
        end
    end

    function automatic logic [15:0] model_rd(input logic [2:0] a);
        case (a)
            3'd0: return {15'd0, m_ime};
            3'd1: return m_en[15:0];
            3'd2: return m_en[31:16];
            3'd3: return m_pend[15:0];
            3'd4: return m_pend[31:16];
            default: return 16'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6", "irq_req vs model", {31'd0, irq_req}, {31'd0, m_irq});
            chk("R8", "irq_out vs model", {31'd0, irq_out}, {31'd0, m_irq && !cpu_irq_dis});
            chk("R9", "halted vs model", {31'd0, halted}, {31'd0, m_halted});
            chk("R10", "wake vs model", {31'd0, wake}, {31'd0, m_wake});
            chk("R2", "rd_data vs model", {16'd0, rd_data}, {16'd0, model_rd(rd_addr)});
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        step();
        wr_en = 0; wr_data = 0;
    endtask

    task automatic pulse(input logic [31:0] s);
        src_i = s;
        step();
        src_i = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [15:0] exp);
        rd_addr = a;
        #1;
        chk(tag, "register read", {16'd0, rd_data}, {16'd0, exp});
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        // R1 reset state
        for (int a = 0; a < 5; a++) rd_chk("R1", 3'(a), 16'h0000);
        chk("R1", "irq_req", {31'd0, irq_req}, 0);
        chk("R1", "halted", {31'd0, halted}, 0);
        chk("R1", "wake", {31'd0, wake}, 0);
        // R2 read back
        wr(3'd1, 16'h00F0);
        wr(3'd2, 16'h8001);
        wr(3'd0, 16'hFFFF);
        rd_chk("R2", 3'd1, 16'h00F0);
        rd_chk("R2", 3'd2, 16'h8001);
        rd_chk("R2", 3'd0, 16'h0001);
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h0000);
        wr(3'd2, 16'h0000);
        // R3 sources set pending
        pulse(32'h0010_0008);
        rd_chk("R3", 3'd3, 16'h0008);
        rd_chk("R3", 3'd4, 16'h0010);
        // R4 write-1-to-clear
        wr(3'd3, 16'h0000);
        rd_chk("R4", 3'd3, 16'h0008);
        wr(3'd3, 16'h0008);
        rd_chk("R4", 3'd3, 16'h0000);
        rd_chk("R4", 3'd4, 16'h0010);
        wr(3'd4, 16'h0010);
        rd_chk("R4", 3'd4, 16'h0000);
        // R5 set beats clear
        src_i = 32'h0000_0020;
        wr(3'd3, 16'h0020);
        src_i = 0;
        rd_chk("R5", 3'd3, 16'h0020);
        // R6 re-evaluation on enable and master writes
        wr(3'd1, 16'h0020);
        chk("R6", "no request with master off", {31'd0, irq_req}, 0);
        cpu_irq_dis = 1;
        wr(3'd0, 16'h0001);
        chk("R6", "request after master write", {31'd0, irq_req}, 1);
        // R8 held while disabled
        chk("R8", "held output", {31'd0, irq_out}, 0);
        cpu_irq_dis = 0;
        #1;
        chk("R8", "delivered on flag clear", {31'd0, irq_out}, 1);
        // R7 drop after clear
        wr(3'd3, 16'h0020);
        chk("R7", "request dropped", {31'd0, irq_req}, 0);
        pulse(32'h0000_0020);
        chk("R6", "request after source", {31'd0, irq_req}, 1);
        wr(3'd0, 16'h0000);
        chk("R7", "dropped with master off", {31'd0, irq_req}, 0);
        wr(3'd3, 16'hFFFF);
        // R9..R11 halt and wake
        wr(3'd1, 16'h0080);
        halt_req = 1;
        step();
        halt_req = 0;
        chk("R9", "halted", {31'd0, halted}, 1);
        pulse(32'h0000_0200);
        chk("R11", "still halted", {31'd0, halted}, 1);
        rd_chk("R11", 3'd3, 16'h0200);
        pulse(32'h0000_0080);
        chk("R10", "woken", {31'd0, halted}, 0);
        chk("R10", "wake pulse", {31'd0, wake}, 1);
        step();
        chk("R10", "wake one cycle", {31'd0, wake}, 0);
        // R12 undefined addresses
        for (int a = 5; a < 8; a++) begin
            wr(3'(a), 16'hFFFF);
            rd_chk("R12", 3'(a), 16'h0000);
        end
        rd_chk("R12", 3'd1, 16'h0080);
        rd_chk("R12", 3'd0, 16'h0000);
        // mixed stimulus, compared against the model every cycle
        for (int i = 0; i < 600; i++) begin
            src_i = ($urandom % 6 == 0) ? (32'd1 << ($urandom % 32)) : 32'd0;
            wr_en = ($urandom % 4 == 0);
            wr_addr = 3'($urandom % 8);
            wr_data = 16'($urandom);
            rd_addr = 3'($urandom % 8);
            cpu_irq_dis = ($urandom % 3 == 0);
            halt_req = ($urandom % 12 == 0);
            step();
        end
        src_i = 0; wr_en = 0; halt_req = 0; cpu_irq_dis = 0;
        step();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule